// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Port Model

This block models, in synthesizable form, the device side of a converter's serial port. It moves through three states: converting, sleeping with a result ready, and shifting that result out. The conversion itself is not modelled. A busy counter stands in for it, and its length depends on the selected oversampling code. When the count expires, the block asks for a result word on a valid/ready input stream. It accepts the word on the handshake and then sleeps.

While chip select is low, the data output line shows the conversion status. It reads 1 while converting and 0 while asleep. The first rising serial clock edge with chip select low starts the transfer. The result is then shifted out most significant bit first, and a 13-bit configuration stream is captured from the serial input at the same time. That stream selects the input channel and the speed for the next conversion. Raising chip select during a transfer abandons it and starts a new conversion.

The serial clock comes either from the host on `sck_in` or from an internal divider on `sck_out`, chosen by a mode pin. The result stream obeys these back-pressure rules. `res_ready` rises only once the busy count has expired. It then stays high, and the block remains in conversion with a status of 1, until `res_valid` is seen high at a clock edge. `res_data` is taken on that edge. `res_valid` is ignored while `res_ready` is low.

Top module: `dsm_serial_port`

## Requirements
- R1: After reset the active configuration is channel code 00000 (differential, first input pair), oversampling code 0011 and 1X mode. The first conversion lasts BUSY_BASE<<2 clock cycles.
- R2: `sdo_oe` is 0 whenever `cs_n` is 1 (line released) and 1 whenever `cs_n` is 0.
- R3: With `cs_n` low, `sdo` is 1 throughout a conversion. It is 0 from the cycle after the result word is accepted until the transfer starts.
- R4: `res_ready` is high only in conversion after the busy count has elapsed. It holds until a cycle with `res_valid` high, and `res_data` is captured in that cycle.
- R5: The sleep state is left only on a rising serial clock edge seen while `cs_n` is low. Edges while `cs_n` is high are ignored.
- R6: Falling edge k of a transfer (k = 0 for the first) drives result bit 31-k on `sdo`. The rising edge after the 32nd falling edge ends the transfer and starts a conversion.
- R7: A rising edge on `cs_n` during a transfer abandons it and starts a conversion in the same cycle.
- R8: `sdi` is sampled on rising edges, with the edge that starts the transfer first. Stream bits 0..2 equal to 1,0,1 mark an update. The update then sets the channel code from bits 3..7 (bit 3 is channel bit 4), the oversampling code from bits 8..11 (bit 8 is its bit 3) and the 2X flag from bit 12. The new settings apply from the next conversion, shown on `conv_*`.
- R9: A preamble other than 1,0,1 leaves every setting unchanged.
- R10: A transfer that ends before bit 12 is received changes no setting.
- R11: An oversampling code of 0000 or 1010..1110 in an update keeps the previous code and 2X flag. The channel code is still updated.
- R12: A conversion lasts BUSY_BASE<<(code-1) cycles for codes 1..9 and BUSY_BASE<<9 for code 1111. The count is halved in 2X mode, with a minimum of 1.
- R13: With `int_clk_sel` = 1, `sck_out` toggles every SCK_HALF cycles while `cs_n` is low and no conversion runs, and is 0 otherwise. `sck_in` is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_clk_sel | input | 1 | 1: internal serial clock, 0: serial clock from `sck_in` |
| cs_n | input | 1 | Active-low chip select |
| sck_in | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial configuration input |
| res_data | input | RES_W | Result word of the finished conversion |
| res_valid | input | 1 | Result word valid |
| res_ready | output | 1 | Block ready to accept the result word |
| sck_out | output | 1 | Internally generated serial clock |
| sdo | output | 1 | Status bit or result data bit |
| sdo_oe | output | 1 | Output enable for `sdo` |
| conv_chan | output | 5 | Channel code of the current conversion |
| conv_osr | output | 4 | Oversampling code of the current conversion |
| conv_twox | output | 1 | 2X mode of the current conversion |

## Verification
A wrong state shows on `sdo` at once whenever chip select is low. A conversion that ends too early or too late moves the rise of `res_ready` by the same number of cycles, and a result shifted from the wrong state misaligns every following data bit. A configuration captured wrongly stays hidden until the next conversion starts. It then appears on `conv_*` in that cycle, and as a changed busy length when the count expires. A bad internal clock divider shows on `sck_out` within one half period.

// File: rtl/dsm_port_pkg.sv
package dsm_port_pkg;

  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_XFER  = 2'd2
  } port_state_e;

  typedef struct packed {
    logic [4:0] chan;
    logic [3:0] osr;
    logic       twox;
  } conv_cfg_t;

  localparam conv_cfg_t CFG_POWERUP = '{chan: 5'b00000, osr: 4'b0011, twox: 1'b0};

  // number of bits in a full programming stream and the update preamble
  localparam int unsigned PROG_BITS = 13;
  localparam logic [2:0]  PRE_UPDATE = 3'b101;

  function automatic logic osr_code_ok(input logic [3:0] code);
    return ((code >= 4'd1) && (code <= 4'd9)) || (code == 4'd15);
  endfunction

  function automatic int unsigned busy_cycles(input int unsigned base, input conv_cfg_t c);
    int unsigned sh;
    int unsigned n;
    if (c.osr == 4'd15) sh = 32'd9;
    else if (c.osr == 4'd0) sh = 32'd0;
    else sh = {28'd0, c.osr} - 32'd1;
    n = base << sh;
    if (c.twox) n = n >> 1;
    if (n == 0) n = 1;
    return n;
  endfunction

endpackage

// File: rtl/dsm_sck_gen.sv
module dsm_sck_gen #(
  parameter int unsigned HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck
);
  localparam int unsigned HC_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [HC_W-1:0] hc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck <= 1'b0;
      hc  <= '0;
    end else if (!run) begin
      sck <= 1'b0;
      hc  <= '0;
    end else if (hc == HC_W'(HALF - 1)) begin
      sck <= ~sck;
      hc  <= '0;
    end else begin
      hc <= hc + 1'b1;
    end
  end

  // R13: clock parks low as soon as it is not allowed to run
  p_idle_low_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sck);

endmodule

// File: rtl/dsm_busy_timer.sv
module dsm_busy_timer
  import dsm_port_pkg::*;
#(
  parameter int unsigned BUSY_BASE = 4,
  parameter int unsigned CNT_W     = 24
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  conv_cfg_t cfg,
  output logic      done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= CNT_W'(busy_cycles(BUSY_BASE, CFG_POWERUP));
    else if (load)       cnt <= CNT_W'(busy_cycles(BUSY_BASE, cfg));
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // R12: a fresh load never reports completion in the following cycle
  p_load_not_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !done);

endmodule

// File: rtl/dsm_cfg_rx.sv
module dsm_cfg_rx
  import dsm_port_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic [IDX_W-1:0] idx,
  input  logic             sdi,
  output conv_cfg_t        pend
);
  logic [PROG_BITS-1:0] rx;
  logic                 last_bit;
  logic                 upd;
  logic [3:0]           osr_new;
  logic [4:0]           chan_new;

  assign last_bit = cap && (idx == IDX_W'(PROG_BITS - 1));
  assign upd      = last_bit && ({rx[0], rx[1], rx[2]} == PRE_UPDATE);
  assign chan_new = {rx[3], rx[4], rx[5], rx[6], rx[7]};
  assign osr_new  = {rx[8], rx[9], rx[10], rx[11]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx <= '0;
    end else begin
      for (int i = 0; i < int'(PROG_BITS); i++) begin
        if (cap && (idx == IDX_W'(i))) rx[i] <= sdi;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= CFG_POWERUP;
    end else if (upd) begin
      pend.chan <= chan_new;
      if (osr_code_ok(osr_new)) begin
        pend.osr  <= osr_new;
        pend.twox <= sdi;
      end
    end
  end

  // R11: the held speed code is always one of the defined ones
  p_osr_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    osr_code_ok(pend.osr));

  // R9 / R10: settings move only on the last bit of an update stream
  p_stable_unless_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(pend));

endmodule

// File: rtl/dsm_serial_port.sv
module dsm_serial_port
  import dsm_port_pkg::*;
#(
  parameter int unsigned RES_W     = 32,
  parameter int unsigned BUSY_BASE = 4,
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned SCK_HALF  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_clk_sel,
  input  logic             cs_n,
  input  logic             sck_in,
  input  logic             sdi,
  input  logic [RES_W-1:0] res_data,
  input  logic             res_valid,
  output logic             res_ready,
  output logic             sck_out,
  output logic             sdo,
  output logic             sdo_oe,
  output logic [4:0]       conv_chan,
  output logic [3:0]       conv_osr,
  output logic             conv_twox
);
  localparam int unsigned RC_W = $clog2(RES_W + 1);

  port_state_e      st;
  logic             sck_gen, sck_eff, sck_q, cs_q;
  logic             rise, fall, cs_rise;
  logic             start_xfer, in_xfer, abort, finish, go_conv, take, cap;
  logic             tmr_done, gen_run;
  logic [RC_W-1:0]  rcnt, cap_idx;
  logic [RES_W-1:0] shreg;
  logic             sdo_bit;
  conv_cfg_t        pend, act;

  // serial clock source and edge detection
  assign gen_run = int_clk_sel && !cs_n && (st != ST_CONV);

  dsm_sck_gen #(.HALF(SCK_HALF)) u_sck (
    .clk(clk), .rst_n(rst_n), .run(gen_run), .sck(sck_gen)
  );

  assign sck_eff = int_clk_sel ? sck_gen : sck_in;
  assign rise    = sck_eff && !sck_q;
  assign fall    = !sck_eff && sck_q;
  assign cs_rise = cs_n && !cs_q;

  // state decode
  assign in_xfer    = (st == ST_XFER);
  assign start_xfer = (st == ST_SLEEP) && rise && !cs_n;
  assign abort      = in_xfer && cs_rise;
  assign finish     = in_xfer && !cs_rise && rise && (rcnt == RC_W'(RES_W));
  assign go_conv    = abort || finish;
  assign res_ready  = (st == ST_CONV) && tmr_done;
  assign take       = res_ready && res_valid;
  assign cap        = start_xfer ||
                      (in_xfer && rise && !cs_rise && (rcnt != RC_W'(RES_W)));
  assign cap_idx    = start_xfer ? '0 : rcnt;

  dsm_busy_timer #(.BUSY_BASE(BUSY_BASE), .CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(go_conv), .cfg(pend), .done(tmr_done)
  );

  dsm_cfg_rx #(.IDX_W(RC_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cap(cap), .idx(cap_idx), .sdi(sdi), .pend(pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_CONV;
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      rcnt    <= '0;
      shreg   <= '0;
      sdo_bit <= 1'b0;
      act     <= CFG_POWERUP;
    end else begin
      sck_q <= sck_eff;
      cs_q  <= cs_n;
      unique case (st)
        ST_CONV: begin
          if (take) begin
            st    <= ST_SLEEP;
            shreg <= res_data;
          end
        end
        ST_SLEEP: begin
          if (start_xfer) begin
            st      <= ST_XFER;
            rcnt    <= RC_W'(1);
            sdo_bit <= 1'b0;
          end
        end
        ST_XFER: begin
          if (go_conv) begin
            st  <= ST_CONV;
            act <= pend;
          end else if (rise) begin
            rcnt <= rcnt + 1'b1;
          end else if (fall) begin
            sdo_bit <= shreg[RES_W-1];
            shreg   <= {shreg[RES_W-2:0], 1'b0};
          end
        end
        default: st <= ST_CONV;
      endcase
    end
  end

  always_comb begin
    unique case (st)
      ST_CONV:  sdo = 1'b1;
      ST_SLEEP: sdo = 1'b0;
      default:  sdo = sdo_bit;
    endcase
  end

  assign sdo_oe    = !cs_n;
  assign sck_out   = sck_gen;
  assign conv_chan = act.chan;
  assign conv_osr  = act.osr;
  assign conv_twox = act.twox;

  // R3: accepting the result clears the status bit on the next cycle
  p_eoc_low_after_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> !sdo);

  // R4: ready is not withdrawn while the word is not taken
  p_ready_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ready && !res_valid) |=> res_ready);

  // R7: chip select rising mid-transfer restarts a conversion at once
  p_abort_restarts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && cs_rise) |=> ((st == ST_CONV) && !res_ready && sdo));

  // R6: the rising-edge counter never passes the word length
  p_rcnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_xfer |-> (rcnt <= RC_W'(RES_W)));

  // R8: active settings change only when a conversion starts
  p_cfg_at_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !go_conv |=> $stable({conv_chan, conv_osr, conv_twox}));

endmodule

// File: tb/test_dsm_serial_port.sv
module test_dsm_serial_port;
  localparam int RES_W = 32;
  localparam int BASE  = 4;
  localparam int HALF  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic int_clk_sel = 1'b0;
  logic cs_n = 1'b1;
  logic sck_in = 1'b0;
  logic sdi = 1'b0;
  logic res_valid = 1'b0;
  logic [RES_W-1:0] res_data = '0;
  logic res_ready, sck_out, sdo, sdo_oe, conv_twox;
  logic [4:0] conv_chan;
  logic [3:0] conv_osr;

  always #5 clk = ~clk;

  dsm_serial_port #(.RES_W(RES_W), .BUSY_BASE(BASE), .CNT_W(24), .SCK_HALF(HALF)) i_dsm_serial_port (
    .clk(clk), .rst_n(rst_n), .int_clk_sel(int_clk_sel), .cs_n(cs_n), .sck_in(sck_in),
    .sdi(sdi), .res_data(res_data), .res_valid(res_valid), .res_ready(res_ready),
    .sck_out(sck_out), .sdo(sdo), .sdo_oe(sdo_oe), .conv_chan(conv_chan),
    .conv_osr(conv_osr), .conv_twox(conv_twox)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_st, m_tmr, m_rc, m_hc;
  logic [31:0] m_sh;
  logic m_bit, m_sck, m_sckq, m_csq;
  logic m_rx[$];
  int p_chan, p_osr, p_twox, a_chan, a_osr, a_twox;

  function automatic int busy(input int osr, input int twox);
    int s;
    int n;
    s = (osr == 15) ? 9 : osr - 1;
    n = BASE << s;
    if (twox != 0) n = n / 2;
    if (n < 1) n = 1;
    return n;
  endfunction

  function automatic bit legal(input int o);
    return (o >= 1 && o <= 9) || o == 15;
  endfunction

  task automatic m_restart();
    a_chan = p_chan; a_osr = p_osr; a_twox = p_twox;
    m_tmr = busy(p_osr, p_twox);
    m_st = 0;
  endtask

  task automatic m_push(input logic b);
    int o;
    if (m_rx.size() < 13) begin
      m_rx.push_back(b);
      if (m_rx.size() == 13 && m_rx[0] && !m_rx[1] && m_rx[2]) begin
        p_chan = {m_rx[3], m_rx[4], m_rx[5], m_rx[6], m_rx[7]};
        o = {m_rx[8], m_rx[9], m_rx[10], m_rx[11]};
        if (legal(o)) begin
          p_osr = o;
          p_twox = m_rx[12];
        end
      end
    end
  endtask

  always @(posedge clk) begin
    logic eff, rise, fall, csr, run, n_sck;
    int n_hc;
    if (!rst_n) begin
      m_st = 0; m_tmr = busy(3, 0); m_rc = 0; m_hc = 0; m_sh = 0; m_bit = 0;
      m_sck = 0; m_sckq = 0; m_csq = 1; m_rx.delete();
      p_chan = 0; p_osr = 3; p_twox = 0; a_chan = 0; a_osr = 3; a_twox = 0;
    end else begin
      eff  = int_clk_sel ? m_sck : sck_in;
      rise = eff && !m_sckq;
      fall = !eff && m_sckq;
      csr  = cs_n && !m_csq;
      run  = int_clk_sel && !cs_n && (m_st != 0);
      if (!run) begin n_sck = 0; n_hc = 0; end
      else if (m_hc == HALF - 1) begin n_sck = !m_sck; n_hc = 0; end
      else begin n_sck = m_sck; n_hc = m_hc + 1; end
      case (m_st)
        0: begin
          if (m_tmr == 0 && res_valid) begin m_sh = res_data; m_st = 1; end
          else if (m_tmr > 0) m_tmr--;
        end
        1: begin
          if (rise && !cs_n) begin
            m_st = 2; m_rc = 1; m_bit = 0; m_rx.delete(); m_push(sdi);
          end
        end
        default: begin
          if (csr) m_restart();
          else if (rise) begin
            if (m_rc == 32) m_restart();
            else begin m_push(sdi); m_rc++; end
          end else if (fall) begin
            m_bit = m_sh[31];
            m_sh = m_sh << 1;
          end
        end
      endcase
      m_sckq = eff; m_csq = cs_n; m_sck = n_sck; m_hc = n_hc;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2", sdo_oe, !cs_n, "sdo_oe");
      if (!cs_n) check((m_st == 2) ? "R6" : "R3", sdo, (m_st == 0) ? 1 : (m_st == 1) ? 0 : m_bit, "sdo");
      check((m_st == 0) ? "R12" : "R4", res_ready, (m_st == 0 && m_tmr == 0), "res_ready");
      check("R8", {conv_chan, conv_osr, conv_twox}, {a_chan[4:0], a_osr[3:0], a_twox[0]}, "active config");
      check("R13", sck_out, m_sck, "sck_out");
    end
  end

  // internal clock monitor: sdo seen at each rising sck_out
  logic isamp[$];
  logic sck_prev = 1'b0;
  always @(negedge clk) begin
    if (int_clk_sel && sck_out && !sck_prev) isamp.push_back(sdo);
    sck_prev = sck_out;
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- host tasks ----------------
  task automatic clk_wait(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic accept(input logic [31:0] w);
    while (!res_ready) clk_wait(1);
    res_valid = 1'b1; res_data = w;
    clk_wait(1);
    res_valid = 1'b0; res_data = '0;
  endtask

  // p[12] is sent first
  task automatic xfer_ext(input logic [12:0] p, input int nrises, output logic [31:0] w);
    w = '0;
    for (int i = 0; i < nrises; i++) begin
      if (i >= 1) w[32 - i] = sdo;
      sdi = (i < 13) ? p[12 - i] : 1'b0;
      sck_in = 1'b1; clk_wait(2);
      sck_in = 1'b0; clk_wait(2);
    end
    sdi = 1'b0;
  endtask

  function automatic logic [9:0] cfgv(input logic [4:0] c, input logic [3:0] o, input logic t);
    return {c, o, t};
  endfunction

  initial begin
    logic [31:0] w;
    int waited;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1: reset state
    check("R1", {conv_chan, conv_osr, conv_twox}, cfgv(5'b00000, 4'b0011, 1'b0), "reset config");
    check("R1", res_ready, 0, "res_ready after reset");
    check("R2", sdo_oe, 0, "sdo_oe with cs_n high");
    waited = 0;
    cs_n = 1'b0;
    clk_wait(1); waited++;
    check("R3", sdo, 1, "status while converting");
    while (!res_ready && waited < 1000) begin clk_wait(1); waited++; end
    check("R1", waited, 16, "first conversion length");

    // R4: back-pressure holds ready and status
    clk_wait(5);
    check("R4", res_ready, 1, "ready held");
    check("R3", sdo, 1, "status held while result pending");
    accept(32'hA5C3_1E96);
    check("R3", sdo, 0, "status after accept");
    check("R4", res_ready, 0, "ready after accept");

    // R5: edges with cs_n high are ignored
    cs_n = 1'b1;
    sck_in = 1'b1; clk_wait(2); sck_in = 1'b0; clk_wait(2);
    cs_n = 1'b0; clk_wait(1);
    check("R5", sdo, 0, "still asleep");

    // R8/R6/R12: update, channel 10110, code 0001, 2X
    xfer_ext(13'b101_10110_0001_1, 33, w);
    check("R6", w, 32'hA5C3_1E96, "shifted word");
    check("R8", {conv_chan, conv_osr, conv_twox}, cfgv(5'b10110, 4'b0001, 1'b1), "new config");
    check("R12", res_ready, 1, "2X shortest conversion elapsed");

    // R9: preamble 100 ignored
    accept(32'h0F0F_8001);
    xfer_ext(13'b100_00011_0101_0, 33, w);
    check("R6", w, 32'h0F0F_8001, "shifted word 2");
    check("R9", {conv_chan, conv_osr, conv_twox}, cfgv(5'b10110, 4'b0001, 1'b1), "config kept");

    // R11: illegal code keeps speed, channel updated
    accept(32'h8000_0001);
    xfer_ext(13'b101_00011_1100_0, 33, w);
    check("R6", w, 32'h8000_0001, "shifted word 3");
    check("R11", {conv_chan, conv_osr, conv_twox}, cfgv(5'b00011, 4'b0001, 1'b1), "speed kept");

    // R7/R10: abort after 8 rising edges
    accept(32'h1234_5678);
    xfer_ext(13'b101_11111_0010_0, 8, w);
    cs_n = 1'b1; clk_wait(1);
    check("R7", res_ready, 0, "conversion restarted");
    check("R10", {conv_chan, conv_osr, conv_twox}, cfgv(5'b00011, 4'b0001, 1'b1), "partial ignored");
    cs_n = 1'b0; clk_wait(1);
    check("R7", sdo, 1, "status busy after abort");

    // R12: longest code 1111 in 1X
    accept(32'hDEAD_BEEF);
    xfer_ext(13'b101_00101_1111_0, 33, w);
    check("R8", {conv_chan, conv_osr, conv_twox}, cfgv(5'b00101, 4'b1111, 1'b0), "code 1111 config");
    waited = 0;
    while (!res_ready && waited < 5000) begin clk_wait(1); waited++; end
    check("R12", waited, 2045, "longest conversion remaining cycles");

    // R13: internal clock mode, sck_in held high and ignored
    accept(32'h6C39_F0A2);
    int_clk_sel = 1'b1; sck_in = 1'b1; sdi = 1'b0;
    isamp.delete();
    waited = 0;
    while (isamp.size() < 33 && waited < 2000) begin clk_wait(1); waited++; end
    w = '0;
    for (int i = 1; i < 33 && i < isamp.size(); i++) w[32 - i] = isamp[i];
    check("R13", w, 32'h6C39_F0A2, "word on internal clock");
    check("R13", isamp.size() > 0 ? isamp[0] : 1'b1, 0, "status bit before first data bit");
    clk_wait(4);
    check("R9", {conv_chan, conv_osr, conv_twox}, cfgv(5'b00101, 4'b1111, 1'b0), "zero stream ignored");
    check("R13", sck_out, 0, "clock parked in conversion");
    cs_n = 1'b1; clk_wait(2);
    check("R2", sdo_oe, 0, "released with cs_n high");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule